// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher, using an 8-bit datapath. Plaintext and key enter together, one byte of each per clock, while `loadEn` is held. A one-cycle `startReq` then launches ten rounds of byte-serial processing. The ciphertext is read back one byte per clock while `unloadEn` is held. The whole block is fixed at AES-128: there is no decryption, no longer key and no wider datapath.

A single counter sequences everything. Its upper nibble is the round number and its lower nibble is the byte step within the round. Every round takes 16 cycles and a run takes exactly 160. The initial key whitening is applied while the bytes are loaded.

The state is held as sixteen byte registers. They are filled by the load strobe and rewritten a column at a time from the MixColumns output. ShiftRows needs no data movement: a per-row rotation that grows each round is folded into the addresses. One S-box serves the data path and a second serves the byte-serial key schedule.

Top module: `aes_byte_enc`

## Requirements
- R1: While the core is idle and `loadEn` is high (with `startReq` low), each clock stores `dataByte` and `keyByte` at the current byte pointer. The pointer then advances, wrapping after 15. Byte index i is row i mod 4 of column i div 4, so byte 0 goes first.
- R2: A `startReq` taken while idle raises `busy` on the next cycle. `busy` then stays high for exactly 160 cycles and resets the byte pointer to 0.
- R3: `done` rises in the same cycle that `busy` falls. It stays high until the next accepted load or start, and it is never high together with `busy`.
- R4: When idle with `unloadEn` high and `startReq` and `loadEn` low, `outByte` shows the ciphertext byte at the pointer, in the same byte order as R1. The pointer advances at each such clock. The ciphertext is AES-128 of the loaded plaintext under the loaded key.
- R5: Plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a, with the first byte on the left.
- R6: `startReq` while busy is ignored: the run neither restarts nor stretches.
- R7: `loadEn` and `unloadEn` while busy are ignored: the result and the pointer are unchanged.
- R8: `outByte` is 0 in every cycle that is not an unload cycle as defined in R4.
- R9: When `rstN` is low at a clock edge (synchronous, active low), `busy`, `done` and the byte pointer are cleared.
- R10: In an idle cycle, `startReq` takes priority over `loadEn`, and `loadEn` takes priority over `unloadEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadEn | input | 1 | Store one plaintext and key byte per cycle |
| unloadEn | input | 1 | Present one ciphertext byte per cycle |
| startReq | input | 1 | Launch an encryption |
| keyByte | input | 8 | Key byte for loading |
| dataByte | input | 8 | Plaintext byte for loading |
| outByte | output | 8 | Ciphertext byte during unload, else 0 |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | Result ready, new input may be loaded |

## Verification
The bench holds a behavioural cipher and a cycle model of the handshake, and compares `busy`, `done` and `outByte` on every clock.

It targets start and load pulses issued in the middle of a run. A design that honoured them would stretch `busy` or corrupt the ciphertext. It also drives start and load together, and load and unload together. Wrong priority would show up as a shifted byte pointer or a run that never began.

A reset in the middle of a run must drop `busy` and `done` at once. The final round must omit MixColumns, and the key schedule must keep its round constant in step. Any slip in either would garble the reference vector in every byte.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int BYTES    = 16;
  localparam int ROUNDS   = 10;
  localparam int IDX_W    = $clog2(BYTES);
  localparam int RND_W    = $clog2(ROUNDS + 1);
  localparam int CNT_W    = RND_W + IDX_W;
  localparam int LAST_CNT = ROUNDS * BYTES - 1;

  typedef logic [7:0] byte_t;
  typedef logic [3:0][7:0] column_t;

  typedef struct packed {
    logic             loadByte;
    logic             unloadByte;
    logic             runStep;
    logic             lastRound;
    logic [IDX_W-1:0] ioIdx;
    logic [RND_W-1:0] round;
    logic [IDX_W-1:0] step;
  } ctrlStrobes_t;

  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gfMul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // x^254 by repeated squaring; maps 0 to 0
  function automatic byte_t gfInv(input byte_t x);
    byte_t pw;
    byte_t acc;
    pw  = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      acc = gfMul(acc, pw);
    end
    return acc;
  endfunction

  function automatic byte_t affineMap(input byte_t x);
    byte_t y;
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
    return y ^ 8'h63;
  endfunction

  function automatic byte_t rconFor(input logic [RND_W-1:0] rnd);
    byte_t r;
    r = 8'h01;
    for (int i = 0; i < ROUNDS - 1; i++)
      if (i < int'(rnd)) r = xtime(r);
    return r;
  endfunction

  function automatic column_t mixColumn(input column_t a);
    column_t o;
    o[0] = xtime(a[0]) ^ xtime(a[1]) ^ a[1] ^ a[2] ^ a[3];
    o[1] = a[0] ^ xtime(a[1]) ^ xtime(a[2]) ^ a[2] ^ a[3];
    o[2] = a[0] ^ a[1] ^ xtime(a[2]) ^ xtime(a[3]) ^ a[3];
    o[3] = xtime(a[0]) ^ a[0] ^ a[1] ^ a[2] ^ xtime(a[3]);
    return o;
  endfunction

  // physical column of logical (row, col) under a per-row rotation of row*rot
  function automatic logic [1:0] physCol(input logic [1:0] c, input logic [1:0] r,
                                         input logic [1:0] rot);
    return c + r * rot;
  endfunction
endpackage

// File: rtl/aes_enc_sbox.sv
module aes_enc_sbox
  import aes_enc_pkg::*;
(
  input  byte_t inByte,
  output byte_t outByte
);
  assign outByte = affineMap(gfInv(inByte));
endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
  import aes_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadEn,
  input  logic         unloadEn,
  input  logic         startReq,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         done
);
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] ioIdx;
  logic startTake, loadTake, unloadTake, runEnd;

  assign startTake  = startReq & ~busy;
  assign loadTake   = loadEn & ~busy & ~startReq;
  assign unloadTake = unloadEn & ~busy & ~startReq & ~loadEn;
  assign runEnd     = busy && (cnt == CNT_W'(LAST_CNT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      ioIdx <= '0;
    end else if (busy) begin
      if (runEnd) begin
        busy <= 1'b0;
        done <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (startTake) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      cnt   <= '0;
      ioIdx <= '0;
    end else if (loadTake) begin
      ioIdx <= ioIdx + 1'b1;
      done  <= 1'b0;
    end else if (unloadTake) begin
      ioIdx <= ioIdx + 1'b1;
    end
  end

  always_comb begin
    strb.loadByte   = loadTake;
    strb.unloadByte = unloadTake;
    strb.runStep    = busy;
    strb.round      = cnt[CNT_W-1:IDX_W];
    strb.step       = cnt[IDX_W-1:0];
    strb.lastRound  = (cnt[CNT_W-1:IDX_W] == RND_W'(ROUNDS - 1));
    strb.ioIdx      = ioIdx;
  end
endmodule

// File: rtl/aes_enc_keysched.sv
module aes_enc_keysched
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             loadByte,
  input  logic             runStep,
  input  logic [IDX_W-1:0] ioIdx,
  input  logic [RND_W-1:0] round,
  input  logic [IDX_W-1:0] step,
  input  byte_t            keyByte,
  output column_t          rkCol
);
  byte_t kb [BYTES];
  byte_t subIn, subOut, rc, kNext;
  logic [1:0] col, row;

  assign col   = step[3:2];
  assign row   = step[1:0];
  assign subIn = kb[{2'd3, row + 2'd1}];
  assign rc    = rconFor(round);

  aes_enc_sbox u_ksbox (.inByte(subIn), .outByte(subOut));

  always_comb begin
    if (col == 2'd0)
      kNext = kb[step] ^ subOut ^ ((row == 2'd0) ? rc : 8'h00);
    else
      kNext = kb[step] ^ kb[step - IDX_W'(4)];
  end

  always_comb begin
    for (int i = 0; i < 3; i++) rkCol[i] = kb[{col, 2'(i)}];
    rkCol[3] = kNext;
  end

  always_ff @(posedge clk) begin
    if (loadByte)     kb[ioIdx] <= keyByte;
    else if (runStep) kb[step]  <= kNext;
  end
endmodule

// File: rtl/aes_enc_datapath.sv
module aes_enc_datapath
  import aes_enc_pkg::*;
(
  input  logic         clk,
  input  ctrlStrobes_t strb,
  input  byte_t        dataByte,
  input  byte_t        keyByte,
  input  column_t      rkCol,
  output byte_t        outByte
);
  byte_t st [BYTES];
  logic [2:0][7:0] colBuf;
  logic [1:0] col, row, rot;
  logic [IDX_W-1:0] readIdx, unIdx;
  byte_t sbOut;
  column_t colVec, newCol;

  assign col     = strb.step[3:2];
  assign row     = strb.step[1:0];
  assign rot     = strb.round[1:0] + 2'd1;
  assign readIdx = {physCol(col, row, rot), row};
  assign unIdx   = {physCol(strb.ioIdx[3:2], strb.ioIdx[1:0], 2'(ROUNDS % 4)), strb.ioIdx[1:0]};

  aes_enc_sbox u_dsbox (.inByte(st[readIdx]), .outByte(sbOut));

  assign colVec = {sbOut, colBuf};
  assign newCol = (strb.lastRound ? colVec : mixColumn(colVec)) ^ rkCol;

  always_ff @(posedge clk) begin
    if (strb.loadByte) begin
      st[strb.ioIdx] <= dataByte ^ keyByte;
    end else if (strb.runStep) begin
      if (row != 2'd3) begin
        colBuf <= {sbOut, colBuf[2:1]};
      end else begin
        for (int i = 0; i < 4; i++)
          st[{physCol(col, 2'(i), rot), 2'(i)}] <= newCol[i];
      end
    end
  end

  assign outByte = strb.unloadByte ? st[unIdx] : 8'h00;
endmodule

// File: rtl/aes_byte_enc.sv
module aes_byte_enc
  import aes_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       unloadEn,
  input  logic       startReq,
  input  logic [7:0] keyByte,
  input  logic [7:0] dataByte,
  output logic [7:0] outByte,
  output logic       busy,
  output logic       done
);
  ctrlStrobes_t strb;
  column_t rkCol;

  aes_enc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .unloadEn(unloadEn),
    .startReq(startReq), .strb(strb), .busy(busy), .done(done)
  );

  aes_enc_keysched u_keys (
    .clk(clk), .loadByte(strb.loadByte), .runStep(strb.runStep),
    .ioIdx(strb.ioIdx), .round(strb.round), .step(strb.step),
    .keyByte(keyByte), .rkCol(rkCol)
  );

  aes_enc_datapath u_data (
    .clk(clk), .strb(strb), .dataByte(dataByte), .keyByte(keyByte),
    .rkCol(rkCol), .outByte(outByte)
  );
endmodule

// File: rtl/aes_byte_enc_chk.sv
module aes_byte_enc_chk
  import aes_enc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       loadEn,
  input logic       unloadEn,
  input logic       startReq,
  input logic       busy,
  input logic       done,
  input logic [7:0] outByte
);
  localparam int RUN_LEN = ROUNDS * BYTES;
  localparam int BC_W    = $clog2(RUN_LEN + 1);
  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R2
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);
  // R2
  run_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == BC_W'(RUN_LEN)));
  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyCnt < BC_W'(RUN_LEN - 1)) |=> busy);
  // R3
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  // R8
  idle_out_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(unloadEn && !busy && !startReq && !loadEn) |-> (outByte == 8'h00));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && !done));
endmodule

bind aes_byte_enc aes_byte_enc_chk u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .unloadEn(unloadEn),
  .startReq(startReq), .busy(busy), .done(done), .outByte(outByte)
);

// File: tb/tb_aes_byte_enc.sv
module tb_aes_byte_enc;
  logic clk = 1'b0, rstN = 1'b0;
  logic loadEn = 1'b0, unloadEn = 1'b0, startReq = 1'b0;
  logic [7:0] keyByte = 8'h00, dataByte = 8'h00;
  logic [7:0] outByte;
  logic busy, done;

  aes_byte_enc dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .unloadEn(unloadEn),
    .startReq(startReq), .keyByte(keyByte), .dataByte(dataByte),
    .outByte(outByte), .busy(busy), .done(done)
  );

  always #10ns clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------- behavioural cipher ----------
  logic [7:0] sbRef [256];
  logic [7:0] expT [256];
  int logT [256];

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction
  function automatic logic [7:0] rol8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  initial begin
    logic [7:0] e;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      expT[i] = e;
      logT[e] = i;
      e = e ^ m2(e);
    end
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      inv = (x == 0) ? 8'h00 : expT[(255 - logT[x]) % 255];
      sbRef[x] = inv ^ rol8(inv, 1) ^ rol8(inv, 2) ^ rol8(inv, 3) ^ rol8(inv, 4) ^ 8'h63;
    end
  end

  task automatic aesRef(input logic [7:0] pt [16], input logic [7:0] key [16],
                        output logic [7:0] ct [16]);
    logic [7:0] s [16], t [16], k [16], tmp [4];
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin s[i] = pt[i] ^ key[i]; k[i] = key[i]; end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = sbRef[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = m2(a0) ^ (m2(a1) ^ a1) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ m2(a1) ^ (m2(a2) ^ a2) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ m2(a2) ^ (m2(a3) ^ a3);
          s[4*c+3] = (m2(a0) ^ a0) ^ a1 ^ a2 ^ m2(a3);
        end
      end
      for (int r = 0; r < 4; r++) tmp[r] = sbRef[k[12 + (r+1)%4]];
      for (int r = 0; r < 4; r++) k[r] = k[r] ^ tmp[r] ^ ((r == 0) ? rc : 8'h00);
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = m2(rc);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    ct = s;
  endtask

  // ---------- cycle model of the handshake ----------
  bit mBusy = 0, mDone = 0;
  int mLeft = 0, mPtr = 0;
  logic [7:0] mPt [16], mKey [16], mCt [16];

  initial for (int i = 0; i < 16; i++) begin mPt[i] = 8'h00; mKey[i] = 8'h00; mCt[i] = 8'h00; end

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mLeft = 0; mPtr = 0;
    end else if (mBusy) begin
      mLeft--;
      if (mLeft == 0) begin mBusy = 0; mDone = 1; end
    end else if (startReq) begin
      mBusy = 1; mDone = 0; mLeft = 160; mPtr = 0;
      aesRef(mPt, mKey, mCt);
    end else if (loadEn) begin
      mPt[mPtr] = dataByte; mKey[mPtr] = keyByte;
      mPtr = (mPtr + 1) % 16; mDone = 0;
    end else if (unloadEn) begin
      mPtr = (mPtr + 1) % 16;
    end
  end

  always @(negedge clk) begin
    #2ns;
    if (!finished) begin
      logic [7:0] expOut;
      bit unl;
      unl = !mBusy && !startReq && !loadEn && unloadEn;
      expOut = unl ? mCt[mPtr] : 8'h00;
      check("R2/R6 busy", {7'b0, busy}, {7'b0, mBusy});
      check("R3 done", {7'b0, done}, {7'b0, mDone});
      check(unl ? "R4/R7/R10 outByte" : "R8 outByte idle", outByte, expOut);
    end
  end

  // ---------- stimulus ----------
  task automatic loadBlock(input logic [7:0] p [16], input logic [7:0] k [16], input bit alsoUnload);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      loadEn = 1'b1; unloadEn = alsoUnload; dataByte = p[i]; keyByte = k[i];
    end
    @(negedge clk);
    loadEn = 1'b0; unloadEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic unloadBlock(output logic [7:0] got [16]);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); unloadEn = 1'b1;
      #1ns got[i] = outByte;
    end
    @(negedge clk); unloadEn = 1'b0;
  endtask

  task automatic randBlock(output logic [7:0] b [16]);
    for (int i = 0; i < 16; i++) b[i] = 8'($urandom);
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] p [16], k [16], got [16];
    logic [127:0] ctLit;
    ctLit = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset busy", {7'b0, busy}, 8'h00);
    check("R9 reset done", {7'b0, done}, 8'h00);
    rstN = 1'b1;

    // R1, R5: reference vector loaded in column-major order
    for (int i = 0; i < 16; i++) begin p[i] = 8'(8'h11 * i); k[i] = 8'(i); end
    loadBlock(p, k, 1'b0);
    pulseStart();
    waitIdle();
    check("R3 done after run", {7'b0, done}, 8'h01);
    unloadBlock(got);
    for (int i = 0; i < 16; i++) check("R5 reference vector", got[i], ctLit[127-8*i -: 8]);

    // R6, R7: start, load and unload pulses in the middle of a run
    randBlock(p); randBlock(k);
    loadBlock(p, k, 1'b0);
    pulseStart();
    repeat (40) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk); startReq = 1'b0; loadEn = 1'b1; dataByte = 8'hA5; keyByte = 8'h5A;
    @(negedge clk); loadEn = 1'b0; unloadEn = 1'b1;
    @(negedge clk); unloadEn = 1'b0;
    repeat (60) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    waitIdle();
    unloadBlock(got);

    // R10: load with unload held (load wins), then start with load (start wins)
    randBlock(p); randBlock(k);
    loadBlock(p, k, 1'b1);
    @(negedge clk); startReq = 1'b1; loadEn = 1'b1; dataByte = 8'hFF; keyByte = 8'hFF;
    @(negedge clk); startReq = 1'b0; loadEn = 1'b0;
    check("R10 start over load", {7'b0, busy}, 8'h01);
    waitIdle();
    unloadBlock(got);
    unloadBlock(got); // pointer wraps, same bytes again (R4)

    // R9: reset in the middle of a run
    randBlock(p); randBlock(k);
    loadBlock(p, k, 1'b0);
    pulseStart();
    repeat (50) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 mid-run reset busy", {7'b0, busy}, 8'h00);
    check("R9 mid-run reset done", {7'b0, done}, 8'h00);
    rstN = 1'b1;

    // R4: further random blocks
    for (int n = 0; n < 3; n++) begin
      randBlock(p); randBlock(k);
      loadBlock(p, k, 1'b0);
      pulseStart();
      waitIdle();
      repeat (3) @(negedge clk);
      unloadBlock(got);
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule